// File: doc/BRIEF.md
# Legacy I/O Interrupt Register Block

This block is a byte-addressed register window of 256 bytes that sits behind a simple single-cycle bus. Its core is an 8-source interrupt controller. Peripherals raise pending bits through a set-vector input and drop them through a clear-vector input. Software enables sources through a mask port, retires a source through an acknowledge port, and reads the pending register. A single summary interrupt line goes to a system interrupt aggregator. That line is high while any pending bit is also enabled.

The block also decodes the other legacy ports in the window. A secondary controller stub holds a mask byte but never interrupts. Two DMA mode latches drive outputs. An indirect real-time-clock pair latches an index and forwards data accesses with it. Three interval-timer data ports and a timer control port are passed through as byte strobes. A port-B status byte reflects the level of an external timer-2 output. Writes to the remaining legacy control ports are accepted and dropped. Any access of an unsupported kind is answered with an error pulse. Such an access has no effect on any state or strobe.

Every request is answered in its own cycle. Read data is combinational from the stored state. A register write takes effect at the next rising clock edge.

Top module: `legacy_irq_regs`

## Requirements
- R1: After reset the pending register reads 0x00 and `irq_o` is low. The primary mask port (0x21) reads 0xFF, because the stored enable mask is zero. The secondary mask (0xA1), both DMA mode outputs and `rtc_idx_o` are 0x00.
- R2: A byte write to 0x21 stores the inverse of the data as the enable mask, so a written 1 masks that source. A read of 0x21 returns the byte last written. From the next cycle, `irq_o` equals the OR of (pending AND enable mask).
- R3: A byte write to 0x20 clears pending bit number `wdata_i[3:0]`. An index from 8 to 15 clears nothing. `irq_o` drops in the next cycle if no enabled pending bit remains.
- R4: Each cycle the pending register becomes ((pending OR set_vec_i) AND NOT clr_vec_i). A clear therefore beats a set of the same bit. Any acknowledge in that cycle is applied after this update.
- R5: A byte read of 0x20 returns the pending register in `rdata_o[7:0]` with zeros above. An 8-byte read (`dw_i`=1) of 0x20 returns the pending register zero-extended to 64 bits.
- R6: A read of 0xA0 returns 0x00. A write to 0xA1 stores the byte without inversion, and a read of 0xA1 returns it. The secondary controller never affects `irq_o`.
- R7: A read of 0x61 returns 0x20 when `tmr2_i` is high and 0x00 when it is low.
- R8: A write to 0x70 latches `wdata_i` onto `rtc_idx_o` from the next cycle. A write to 0x71 pulses `rtc_we_o` with `ext_wdata_o` equal to `wdata_i`. A read of 0x71 pulses `rtc_re_o` and returns `rtc_rdata_i`. Both use the latched index.
- R9: A byte write to 0x40 to 0x43 pulses `tmr_we_o`, with `tmr_idx_o` equal to the address low two bits (3 selects control). A byte read of 0x40 to 0x42 pulses `tmr_re_o` and returns `tmr_rdata_i`. At most one forwarding strobe is high in any cycle.
- R10: A write to 0x0B updates `dma_mode_a_o` and a write to 0xD6 updates `dma_mode_b_o`, each from the next cycle. Byte writes to 0x60, 0x61, 0xA0, 0x08, 0x0A, 0x0D, 0x0F, 0xD0, 0xD4, 0xDA and 0xDE are accepted without error and change no state and no strobe.
- R11: Any other access raises `err_o` together with `ready_o`. This covers any 8-byte write, any 8-byte read other than at 0x20, a byte write to an undecoded offset, and a byte read of an offset outside {0x20, 0x21, 0xA0, 0xA1, 0x40 to 0x42, 0x61, 0x71}. Such an access changes no state and raises no forwarding strobe.
- R12: `ready_o` is high in every cycle in which `req_i` is high, and `err_o` is never high without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| dw_i | input | 1 | 1 = 8-byte access, 0 = single byte |
| addr_i | input | 8 | Byte offset within the window |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Access completes this cycle |
| err_o | output | 1 | Access rejected, no effect |
| rdata_o | output | 64 | Read data, zero-extended |
| set_vec_i | input | 8 | Pending bits to set |
| clr_vec_i | input | 8 | Pending bits to clear |
| irq_o | output | 1 | Summary interrupt |
| tmr_we_o | output | 1 | Timer write strobe |
| tmr_re_o | output | 1 | Timer read strobe |
| tmr_idx_o | output | 2 | Timer port select |
| tmr_rdata_i | input | 8 | Timer read data |
| tmr2_i | input | 1 | Timer-2 output level |
| rtc_we_o | output | 1 | RTC data write strobe |
| rtc_re_o | output | 1 | RTC data read strobe |
| rtc_idx_o | output | 8 | Latched RTC index |
| rtc_rdata_i | input | 8 | RTC read data |
| ext_wdata_o | output | 8 | Write data forwarded to timer and RTC |
| dma_mode_a_o | output | 8 | First DMA mode latch |
| dma_mode_b_o | output | 8 | Second DMA mode latch |

## Verification
A pending or enable bit that is wrong shows up in `irq_o` one cycle after the event that caused it. It shows again at once in any read of 0x20 or 0x21. An inverted or missing mask inversion, an acknowledge index that is off by one, and the wrong winner in a set/clear collision each give the wrong value on the next status read. A decode slip appears in the same cycle as the access itself. It can show as an error pulse on a legal offset, a missing pulse on an illegal one, or a stray forwarding strobe. A leaked write to a sink port appears on the DMA outputs, the RTC index or the status reads in the following cycle.

// File: rtl/legacy_irq_pkg.sv
package legacy_irq_pkg;
  localparam logic [7:0] A_PIC1_CMD  = 8'h20;
  localparam logic [7:0] A_PIC1_MSK  = 8'h21;
  localparam logic [7:0] A_PIC2_CMD  = 8'hA0;
  localparam logic [7:0] A_PIC2_MSK  = 8'hA1;
  localparam logic [7:0] A_TMR0      = 8'h40;
  localparam logic [7:0] A_TMR1      = 8'h41;
  localparam logic [7:0] A_TMR2      = 8'h42;
  localparam logic [7:0] A_TMR_CTL   = 8'h43;
  localparam logic [7:0] A_KBD       = 8'h60;
  localparam logic [7:0] A_PORTB     = 8'h61;
  localparam logic [7:0] A_RTC_IDX   = 8'h70;
  localparam logic [7:0] A_RTC_DAT   = 8'h71;
  localparam logic [7:0] A_DMA1_CMD  = 8'h08;
  localparam logic [7:0] A_DMA1_MSK  = 8'h0A;
  localparam logic [7:0] A_DMA1_MODE = 8'h0B;
  localparam logic [7:0] A_DMA1_RST  = 8'h0D;
  localparam logic [7:0] A_DMA1_ALL  = 8'h0F;
  localparam logic [7:0] A_DMA2_CMD  = 8'hD0;
  localparam logic [7:0] A_DMA2_MSK  = 8'hD4;
  localparam logic [7:0] A_DMA2_MODE = 8'hD6;
  localparam logic [7:0] A_DMA2_RST  = 8'hDA;
  localparam logic [7:0] A_DMA2_ALL  = 8'hDE;

  localparam logic [7:0] PORTB_SPK_HI = 8'h20;

  typedef enum logic [2:0] {
    RS_ZERO, RS_PEND, RS_MSK1, RS_MSK2, RS_TMR, RS_RTC, RS_PORTB
  } rsel_e;

  typedef struct packed {
    logic  ok;
    logic  pic1_ack;
    logic  pic1_msk;
    logic  pic2_msk;
    logic  dma1_mode;
    logic  dma2_mode;
    logic  rtc_idx;
    logic  rtc_wr;
    logic  rtc_rd;
    logic  tmr_wr;
    logic  tmr_rd;
    rsel_e rsel;
  } dec_t;
endpackage

// File: rtl/legacy_irq_dec.sv
module legacy_irq_dec
  import legacy_irq_pkg::*;
(
  input  logic       req_i,
  input  logic       we_i,
  input  logic       dw_i,
  input  logic [7:0] addr_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o      = '0;
    dec_o.rsel = RS_ZERO;
    if (req_i) begin
      if (we_i) begin
        if (!dw_i) begin
          dec_o.ok = 1'b1;
          unique case (addr_i)
            A_PIC1_CMD:  dec_o.pic1_ack  = 1'b1;
            A_PIC1_MSK:  dec_o.pic1_msk  = 1'b1;
            A_PIC2_MSK:  dec_o.pic2_msk  = 1'b1;
            A_DMA1_MODE: dec_o.dma1_mode = 1'b1;
            A_DMA2_MODE: dec_o.dma2_mode = 1'b1;
            A_RTC_IDX:   dec_o.rtc_idx   = 1'b1;
            A_RTC_DAT:   dec_o.rtc_wr    = 1'b1;
            A_TMR0, A_TMR1, A_TMR2, A_TMR_CTL: dec_o.tmr_wr = 1'b1;
            // accepted sinks
            A_KBD, A_PORTB, A_PIC2_CMD,
            A_DMA1_CMD, A_DMA1_MSK, A_DMA1_RST, A_DMA1_ALL,
            A_DMA2_CMD, A_DMA2_MSK, A_DMA2_RST, A_DMA2_ALL: ;
            default:     dec_o.ok = 1'b0;
          endcase
        end
      end else if (dw_i) begin
        if (addr_i == A_PIC1_CMD) begin
          dec_o.ok   = 1'b1;
          dec_o.rsel = RS_PEND;
        end
      end else begin
        dec_o.ok = 1'b1;
        unique case (addr_i)
          A_PIC1_CMD: dec_o.rsel = RS_PEND;
          A_PIC1_MSK: dec_o.rsel = RS_MSK1;
          A_PIC2_CMD: dec_o.rsel = RS_ZERO;
          A_PIC2_MSK: dec_o.rsel = RS_MSK2;
          A_PORTB:    dec_o.rsel = RS_PORTB;
          A_RTC_DAT: begin
            dec_o.rsel   = RS_RTC;
            dec_o.rtc_rd = 1'b1;
          end
          A_TMR0, A_TMR1, A_TMR2: begin
            dec_o.rsel   = RS_TMR;
            dec_o.tmr_rd = 1'b1;
          end
          default:    dec_o.ok = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/legacy_irq_pic.sv
module legacy_irq_pic #(
  parameter int NSRC = 8,
  parameter int AIW  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_vec_i,
  input  logic [NSRC-1:0] clr_vec_i,
  input  logic            msk_we_i,
  input  logic [NSRC-1:0] msk_wdata_i,
  input  logic            ack_we_i,
  input  logic [AIW-1:0]  ack_idx_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] en_o,
  output logic            irq_o
);
  logic [NSRC-1:0] pend_q, pend_d, en_q;

  // set, then clear-vector, then acknowledge
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic ack_hit;
    assign ack_hit   = ack_we_i && (ack_idx_i == AIW'(i));
    assign pend_d[i] = ((pend_q[i] | set_vec_i[i]) & ~clr_vec_i[i]) & ~ack_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (msk_we_i) en_q <= ~msk_wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = |(pend_q & en_q);
endmodule

// File: rtl/legacy_irq_aux.sv
module legacy_irq_aux #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          msk2_we_i,
  input  logic          mode_a_we_i,
  input  logic          mode_b_we_i,
  input  logic          rtc_idx_we_i,
  output logic [DW-1:0] msk2_o,
  output logic [DW-1:0] mode_a_o,
  output logic [DW-1:0] mode_b_o,
  output logic [DW-1:0] rtc_idx_o
);
  localparam int NREG = 4;
  logic [NREG-1:0]         we;
  logic [NREG-1:0][DW-1:0] q;

  assign we = {rtc_idx_we_i, mode_b_we_i, mode_a_we_i, msk2_we_i};

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q[r] <= '0;
      else if (we[r]) q[r] <= wdata_i;
    end
  end

  assign msk2_o    = q[0];
  assign mode_a_o  = q[1];
  assign mode_b_o  = q[2];
  assign rtc_idx_o = q[3];
endmodule

// File: rtl/legacy_irq_regs.sv
module legacy_irq_regs
  import legacy_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int RW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          dw_i,
  input  logic [7:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          err_o,
  output logic [RW-1:0] rdata_o,
  input  logic [DW-1:0] set_vec_i,
  input  logic [DW-1:0] clr_vec_i,
  output logic          irq_o,
  output logic          tmr_we_o,
  output logic          tmr_re_o,
  output logic [1:0]    tmr_idx_o,
  input  logic [DW-1:0] tmr_rdata_i,
  input  logic          tmr2_i,
  output logic          rtc_we_o,
  output logic          rtc_re_o,
  output logic [DW-1:0] rtc_idx_o,
  input  logic [DW-1:0] rtc_rdata_i,
  output logic [DW-1:0] ext_wdata_o,
  output logic [DW-1:0] dma_mode_a_o,
  output logic [DW-1:0] dma_mode_b_o
);
  localparam int AIW = 4;

  dec_t          dec;
  logic [DW-1:0] pend, en, msk2;
  logic [DW-1:0] rbyte;

  legacy_irq_dec u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .dw_i   (dw_i),
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  legacy_irq_pic #(.NSRC(DW), .AIW(AIW)) u_pic (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_vec_i   (set_vec_i),
    .clr_vec_i   (clr_vec_i),
    .msk_we_i    (dec.pic1_msk),
    .msk_wdata_i (wdata_i),
    .ack_we_i    (dec.pic1_ack),
    .ack_idx_i   (wdata_i[AIW-1:0]),
    .pend_o      (pend),
    .en_o        (en),
    .irq_o       (irq_o)
  );

  legacy_irq_aux #(.DW(DW)) u_aux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wdata_i      (wdata_i),
    .msk2_we_i    (dec.pic2_msk),
    .mode_a_we_i  (dec.dma1_mode),
    .mode_b_we_i  (dec.dma2_mode),
    .rtc_idx_we_i (dec.rtc_idx),
    .msk2_o       (msk2),
    .mode_a_o     (dma_mode_a_o),
    .mode_b_o     (dma_mode_b_o),
    .rtc_idx_o    (rtc_idx_o)
  );

  always_comb begin
    unique case (dec.rsel)
      RS_PEND:  rbyte = pend;
      RS_MSK1:  rbyte = ~en;
      RS_MSK2:  rbyte = msk2;
      RS_TMR:   rbyte = tmr_rdata_i;
      RS_RTC:   rbyte = rtc_rdata_i;
      RS_PORTB: rbyte = tmr2_i ? PORTB_SPK_HI : '0;
      default:  rbyte = '0;
    endcase
  end

  assign rdata_o     = RW'(rbyte);
  assign ready_o     = req_i;
  assign err_o       = req_i & ~dec.ok;
  assign tmr_we_o    = dec.tmr_wr;
  assign tmr_re_o    = dec.tmr_rd;
  assign tmr_idx_o   = addr_i[1:0];
  assign rtc_we_o    = dec.rtc_wr;
  assign rtc_re_o    = dec.rtc_rd;
  assign ext_wdata_o = wdata_i;
endmodule

// File: rtl/legacy_irq_regs_chk.sv
module legacy_irq_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic        dw_i,
  input logic [7:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic        ready_o,
  input logic        err_o,
  input logic [63:0] rdata_o,
  input logic        irq_o,
  input logic        tmr_we_o,
  input logic        tmr_re_o,
  input logic        rtc_we_o,
  input logic        rtc_re_o,
  input logic        tmr2_i
);
  // R2
  mask_all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !dw_i && addr_i == 8'h21 && wdata_i == 8'hFF) |=> !irq_o);

  // R12
  ready_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> ready_o);

  // R12
  err_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ready_o);

  // R11
  err_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !(tmr_we_o || tmr_re_o || rtc_we_o || rtc_re_o));

  // R9
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tmr_we_o, tmr_re_o, rtc_we_o, rtc_re_o}));

  // R6
  sec_status_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !dw_i && addr_i == 8'hA0) |-> rdata_o == 64'h0);

  // R7
  portb_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !dw_i && addr_i == 8'h61) |-> rdata_o == (tmr2_i ? 64'h20 : 64'h0));
endmodule

bind legacy_irq_regs legacy_irq_regs_chk u_chk (.*);

// File: tb/sim_legacy_irq_regs.sv
module sim_legacy_irq_regs;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 0, we_i = 0, dw_i = 0;
  logic [7:0]  addr_i = 0, wdata_i = 0, set_vec_i = 0, clr_vec_i = 0;
  logic [7:0]  tmr_rdata_i = 8'h3C, rtc_rdata_i = 8'hC3;
  logic        tmr2_i = 0;
  logic        ready_o, err_o, irq_o, tmr_we_o, tmr_re_o, rtc_we_o, rtc_re_o;
  logic [63:0] rdata_o;
  logic [1:0]  tmr_idx_o;
  logic [7:0]  rtc_idx_o, ext_wdata_o, dma_mode_a_o, dma_mode_b_o;

  legacy_irq_regs u0 (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_pend = 0, m_en = 0, m_sec = 0, m_da = 0, m_db = 0, m_rtc = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit is_sink(logic [7:0] a);
    return a inside {8'h60, 8'h61, 8'hA0, 8'h08, 8'h0A, 8'h0D, 8'h0F,
                     8'hD0, 8'hD4, 8'hDA, 8'hDE};
  endfunction

  function automatic bit legal(bit we, bit dw, logic [7:0] a);
    if (we) return !dw && (is_sink(a) || a inside {8'h20, 8'h21, 8'hA1, 8'h0B, 8'hD6,
                                                     8'h70, 8'h71, [8'h40:8'h43]});
    if (dw) return a == 8'h20;
    return a inside {8'h20, 8'h21, 8'hA0, 8'hA1, [8'h40:8'h42], 8'h61, 8'h71};
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      8'h20: return m_pend;
      8'h21: return ~m_en;
      8'hA1: return m_sec;
      8'h40, 8'h41, 8'h42: return tmr_rdata_i;
      8'h61: return tmr2_i ? 8'h20 : 8'h00;
      8'h71: return rtc_rdata_i;
      default: return 8'h00;
    endcase
  endfunction

  // one cycle: drive at negedge, check comb outputs, clock, update model, check irq
  task automatic cyc(bit rq, bit we, bit dw, logic [7:0] a, logic [7:0] wd,
                     logic [7:0] sv, logic [7:0] cv, string tag);
    bit ok;
    ok = rq && legal(we, dw, a);
    req_i = rq; we_i = we; dw_i = dw; addr_i = a; wdata_i = wd;
    set_vec_i = sv; clr_vec_i = cv;
    #1;
    chk("R12 ready", ready_o, rq);
    chk({"R11 err ", tag}, err_o, rq && !ok);
    chk("R9 tmr_we", tmr_we_o, ok && we && a inside {[8'h40:8'h43]});
    chk("R9 tmr_re", tmr_re_o, ok && !we && a inside {[8'h40:8'h42]});
    chk("R8 rtc_we", rtc_we_o, ok && we && a == 8'h71);
    chk("R8 rtc_re", rtc_re_o, ok && !we && a == 8'h71);
    if (tmr_we_o || tmr_re_o) chk("R9 idx", tmr_idx_o, a[1:0]);
    if (rtc_we_o || rtc_re_o) begin
      chk("R8 idx", rtc_idx_o, m_rtc);
      chk("R8 wdata", ext_wdata_o, wd);
    end
    if (ok && !we) chk({"R5 rdata ", tag}, rdata_o, {56'h0, exp_rd(a)});
    @(posedge clk_i);
    m_pend = (m_pend | sv) & ~cv;
    if (ok && we) begin
      case (a)
        8'h20: if (wd[3:0] < 4'd8) m_pend[wd[2:0]] = 1'b0;
        8'h21: m_en = ~wd;
        8'hA1: m_sec = wd;
        8'h0B: m_da = wd;
        8'hD6: m_db = wd;
        8'h70: m_rtc = wd;
        default: ;
      endcase
    end
    @(negedge clk_i);
    req_i = 0; set_vec_i = 0; clr_vec_i = 0;
    #1;
    chk({"R2 irq ", tag}, irq_o, |(m_pend & m_en));
    chk("R10 dma_a", dma_mode_a_o, m_da);
    chk("R10 dma_b", dma_mode_b_o, m_db);
    chk("R8 rtc_idx", rtc_idx_o, m_rtc);
    @(negedge clk_i);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
    cyc(1, 1, 0, a, d, 0, 0, tag);
  endtask
  task automatic rd(logic [7:0] a, string tag);
    cyc(1, 0, 0, a, 0, 0, 0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pick [16];
    void'($urandom(32'd20240611));
    pick = '{8'h20, 8'h21, 8'hA0, 8'hA1, 8'h40, 8'h42, 8'h43, 8'h60,
             8'h61, 8'h70, 8'h71, 8'h0B, 8'hD6, 8'h0F, 8'h30, 8'hDE};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    #1;
    chk("R1 irq", irq_o, 1'b0);
    chk("R1 rtc_idx", rtc_idx_o, 8'h00);
    chk("R1 dma_a", dma_mode_a_o, 8'h00);
    chk("R1 dma_b", dma_mode_b_o, 8'h00);
    @(negedge clk_i);
    rd(8'h20, "R1");
    rd(8'h21, "R1");
    rd(8'hA1, "R1");
    // R2 mask, R4 set
    wr(8'h21, 8'h00, "R2");
    rd(8'h21, "R2");
    cyc(0, 0, 0, 0, 0, 8'h10, 0, "R4 set");
    rd(8'h20, "R5");
    cyc(1, 0, 1, 8'h20, 0, 0, 0, "R5 wide");
    wr(8'h21, 8'h10, "R2 masked");
    rd(8'h21, "R2");
    wr(8'h21, 8'h00, "R2 unmask");
    // R3 ack
    wr(8'h20, 8'h0C, "R3 high index");
    rd(8'h20, "R3");
    wr(8'h20, 8'h04, "R3 clear");
    rd(8'h20, "R3");
    // R4 ordering
    cyc(1, 1, 0, 8'h20, 8'h00, 8'h05, 0, "R4 set+ack");
    rd(8'h20, "R4");
    cyc(0, 0, 0, 0, 0, 8'h03, 8'h01, "R4 set+clr");
    rd(8'h20, "R4");
    cyc(0, 0, 0, 0, 0, 0, 8'h06, "R4 clr");
    // R6 secondary
    wr(8'hA1, 8'h5A, "R6");
    rd(8'hA1, "R6");
    rd(8'hA0, "R6");
    wr(8'h21, 8'hFF, "R6 pri off");
    cyc(0, 0, 0, 0, 0, 8'hFF, 0, "R6 no sec irq");
    // R7 port B
    tmr2_i = 1; rd(8'h61, "R7 high");
    tmr2_i = 0; rd(8'h61, "R7 low");
    // R8 rtc
    wr(8'h70, 8'h0D, "R8");
    wr(8'h71, 8'h77, "R8");
    rd(8'h71, "R8");
    // R9 timer
    for (int i = 0; i < 4; i++) wr(8'h40 + 8'(i), 8'(i + 1), "R9");
    rd(8'h42, "R9");
    // R10 sinks and DMA modes
    wr(8'h0B, 8'hA5, "R10");
    wr(8'hD6, 8'h3C, "R10");
    foreach (pick[i]) if (is_sink(pick[i])) wr(pick[i], 8'hFF, "R10 sink");
    wr(8'h08, 8'hFF, "R10 sink");
    wr(8'hD4, 8'hFF, "R10 sink");
    rd(8'h20, "R10");
    rd(8'h21, "R10");
    rd(8'hA1, "R10");
    // R11 illegal
    cyc(1, 1, 1, 8'h21, 8'h00, 0, 0, "R11 wide wr");
    cyc(1, 0, 1, 8'h21, 0, 0, 0, "R11 wide rd");
    rd(8'h43, "R11");
    rd(8'h0B, "R11");
    rd(8'h70, "R11");
    wr(8'h30, 8'h00, "R11");
    rd(8'h21, "R11");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a, sv, cv;
      bit we, dw, rq;
      a  = ($urandom % 4 == 0) ? 8'($urandom) : pick[$urandom % 16];
      we = $urandom % 2;
      dw = ($urandom % 8) == 0;
      rq = ($urandom % 5) != 0;
      sv = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      cv = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      tmr2_i = $urandom % 2;
      tmr_rdata_i = 8'($urandom);
      rtc_rdata_i = 8'($urandom);
      cyc(rq, we, dw, a, 8'($urandom), sv, cv, "rand");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule